// File: doc/BRIEF.md
# Watchdog Counter with Overflow Reset Control

This block pairs an 8-bit watchdog up-counter with a reset control and status register. Software sets a mode bit to choose between watchdog operation and plain interval counting. When the counter wraps in watchdog mode, the register latches an overflow flag. The same event always clears the watchdog's own counter and control register. If the reset enable bit is set, it also drives a fixed-length internal chip reset pulse. The overflow flag clears only through a two-step sequence: software first reads the flag as set, then writes zero to it.

The register bus is byte wide and has no wait states. A select with a write strobe writes on the clock edge. A select without a write strobe is a read: the read data is combinational in that cycle, and the read's side effects take hold at the edge. There are four addresses:

- 0: timer control. Bit 7 = watchdog mode, bit 6 = run. The other bits read 0.
- 1: counter value.
- 2: reset control/status.
- 3: unused, reads 0x00.

The external reset pin (`rstPinN`, active low, synchronous) is the only event that reinitialises the status register. The chip reset pulse that the block produces leaves that register untouched.

Top module: `wdtResetCtl`

## Requirements
- R1: While the pin reset is low, and after it is released, address 2 reads 0x1F, addresses 0 and 1 read 0x00, and both reset outputs are low.
- R2: The counter (address 1) increments by one on every cycle in which run (address 0 bit 6) and `tickEn` are both high. A write to address 1 takes priority over the increment. Incrementing from 0xFF gives 0x00.
- R3: The overflow flag (address 2 bit 7) becomes 1 on the edge where the counter increments from 0xFF to 0x00 while watchdog mode (address 0 bit 7) is 1. The same wrap in interval mode never sets the flag.
- R4: Writing 1 to address 2 bit 7 never changes the flag.
- R5: A read of address 2 that returns bit 7 as 1 arms a clear. The next write to address 2 with bit 7 equal to 0 consumes that arm and clears the flag. A zero write with no arm leaves the flag at 1.
- R6: If a watchdog overflow falls in the same cycle as an armed zero write, the flag ends at 1.
- R7: A watchdog-mode overflow drives `wdtLocalReset` high for exactly the next cycle. From that cycle on, the counter and address 0 read 0x00.
- R8: If reset enable (address 2 bit 6) is 1 when a watchdog overflow happens, `chipResetOut` is high for exactly PULSE_LEN cycles (default 8), starting the next cycle. During the pulse, the counter stays at 0x00 and ignores both ticks and writes.
- R9: If reset enable is 0 at the overflow, `chipResetOut` stays low.
- R10: Bits 4..0 of address 2 always read 1 and ignore writes. Bit 5 (reset type; 0 = power-on, 1 not to be used) is stored and read back, and it has no effect on either output.
- R11: The chip reset pulse leaves address 2 unchanged, so the flag set by the overflow is still 1 after the pulse. Only the pin reset returns address 2 to 0x1F.
- R12: Address 3 reads 0x00. Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstPinN | input | 1 | External reset pin, active low, synchronous |
| busSel | input | 1 | Register access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| tickEn | input | 1 | Count-enable tick |
| chipResetOut | output | 1 | Internal chip reset pulse |
| wdtLocalReset | output | 1 | One-cycle watchdog-only reset indication |

## Verification
The bound checker watches every cycle for these properties:

- the flag rises only from a watchdog-mode wrap, and never from an interval-mode wrap;
- the flag falls only through an armed zero write;
- a write of one leaves the flag unchanged;
- an overflow wins over a clear in the same cycle;
- the local reset cycle follows each watchdog overflow;
- the counter stays at zero while the chip pulse is high;
- the chip pulse starts only with the enable bit set;
- the reserved bits read as ones.

Some behaviour only the bench scenarios can show. These are the exact pulse length, the flag surviving the chip pulse and being cleared by the pin, the arm being consumed by a collision write, and the reset-type bit having no effect on the outputs.

// File: rtl/wdtRstPkg.sv
package wdtRstPkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_RSTCS = 2'd2,
    REG_NONE  = 2'd3
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic              ctrlWr;     // write timer control
    logic              cntWr;      // load counter
    logic              holdCount;  // chip reset pulse active: force counter to zero
    logic              clearLocal; // watchdog-only reset of counter/control
    logic [DATA_W-1:0] wdata;
  } dpStrobe_t;

endpackage

// File: rtl/wdtDatapath.sv
module wdtDatapath
  import wdtRstPkg::*;
#(
  parameter int CNT_W = DATA_W
) (
  input  logic             clk,
  input  logic             rstPinN,
  input  dpStrobe_t        strobe,
  input  logic             tickEn,
  output logic [CNT_W-1:0] countQ,
  output logic             modeWd,
  output logic             runQ,
  output logic             wrapEvt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic incEn;

  assign incEn   = runQ && tickEn && !strobe.holdCount;
  assign wrapEvt = incEn && !strobe.cntWr && (countQ == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstPinN) begin
      countQ <= '0;
    end else if (strobe.holdCount || strobe.clearLocal) begin
      countQ <= '0;
    end else if (strobe.cntWr) begin
      countQ <= strobe.wdata[CNT_W-1:0];
    end else if (incEn) begin
      countQ <= countQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstPinN) begin
      modeWd <= 1'b0;
      runQ   <= 1'b0;
    end else if (strobe.clearLocal) begin
      modeWd <= 1'b0;
      runQ   <= 1'b0;
    end else if (strobe.ctrlWr) begin
      modeWd <= strobe.wdata[7];
      runQ   <= strobe.wdata[6];
    end
  end

endmodule

// File: rtl/wdtControl.sv
module wdtControl
  import wdtRstPkg::*;
#(
  parameter int PULSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rstPinN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              wrapEvt,
  input  logic              modeWd,
  input  logic              runQ,
  input  logic [DATA_W-1:0] countQ,
  output dpStrobe_t         strobe,
  output logic              chipResetOut,
  output logic              wdtLocalReset,
  output logic              flagQ,
  output logic              armQ,
  output logic              rstEnQ
);

  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_LEN);

  logic          rstTypeQ;
  logic [PW-1:0] pulseCnt;
  logic          wrAccess, rdAccess;
  logic          wrRstcs, rdRstcs;
  logic          wdOverflow, clearReq;

  assign wrAccess   = busSel && busWr;
  assign rdAccess   = busSel && !busWr;
  assign wrRstcs    = wrAccess && (busAddr == REG_RSTCS);
  assign rdRstcs    = rdAccess && (busAddr == REG_RSTCS);
  assign wdOverflow = wrapEvt && modeWd;
  assign clearReq   = wrRstcs && !busWdata[7] && armQ;

  assign chipResetOut = (pulseCnt != '0);

  always_comb begin
    strobe.wdata      = busWdata;
    strobe.holdCount  = chipResetOut;
    strobe.ctrlWr     = wrAccess && (busAddr == REG_CTRL);
    strobe.cntWr      = wrAccess && (busAddr == REG_COUNT) && !chipResetOut;
    strobe.clearLocal = wdOverflow;
  end

  // Overflow flag: overflow set beats an armed clear
  always_ff @(posedge clk) begin
    if (!rstPinN) begin
      flagQ <= 1'b0;
    end else if (wdOverflow) begin
      flagQ <= 1'b1;
    end else if (clearReq) begin
      flagQ <= 1'b0;
    end
  end

  // Arm: set by a read that sees the flag, consumed by a zero write
  always_ff @(posedge clk) begin
    if (!rstPinN) begin
      armQ <= 1'b0;
    end else if (clearReq) begin
      armQ <= 1'b0;
    end else if (rdRstcs && flagQ) begin
      armQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstPinN) begin
      rstEnQ   <= 1'b0;
      rstTypeQ <= 1'b0;
    end else if (wrRstcs) begin
      rstEnQ   <= busWdata[6];
      rstTypeQ <= busWdata[5];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstPinN) begin
      pulseCnt <= '0;
    end else if (wdOverflow && rstEnQ) begin
      pulseCnt <= PULSE_LOAD;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstPinN) begin
      wdtLocalReset <= 1'b0;
    end else begin
      wdtLocalReset <= wdOverflow;
    end
  end

  always_comb begin
    case (busAddr)
      REG_CTRL:  busRdata = {modeWd, runQ, 6'b000000};
      REG_COUNT: busRdata = countQ;
      REG_RSTCS: busRdata = {flagQ, rstEnQ, rstTypeQ, 5'b11111};
      default:   busRdata = '0;
    endcase
  end

endmodule

// File: rtl/wdtResetCtl.sv
module wdtResetCtl
  import wdtRstPkg::*;
#(
  parameter int PULSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rstPinN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tickEn,
  output logic              chipResetOut,
  output logic              wdtLocalReset
);

  dpStrobe_t         strobe;
  logic [DATA_W-1:0] countQ;
  logic              modeWd, runQ, wrapEvt;
  logic              flagQ, armQ, rstEnQ;

  wdtDatapath #(.CNT_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstPinN (rstPinN),
    .strobe  (strobe),
    .tickEn  (tickEn),
    .countQ  (countQ),
    .modeWd  (modeWd),
    .runQ    (runQ),
    .wrapEvt (wrapEvt)
  );

  wdtControl #(.PULSE_LEN(PULSE_LEN)) u_ctrl (
    .clk           (clk),
    .rstPinN       (rstPinN),
    .busSel        (busSel),
    .busWr         (busWr),
    .busAddr       (busAddr),
    .busWdata      (busWdata),
    .busRdata      (busRdata),
    .wrapEvt       (wrapEvt),
    .modeWd        (modeWd),
    .runQ          (runQ),
    .countQ        (countQ),
    .strobe        (strobe),
    .chipResetOut  (chipResetOut),
    .wdtLocalReset (wdtLocalReset),
    .flagQ         (flagQ),
    .armQ          (armQ),
    .rstEnQ        (rstEnQ)
  );

endmodule

// File: rtl/wdtResetCtlChecker.sv
module wdtResetCtlChecker (
  input logic       clk,
  input logic       rstPinN,
  input logic       busSel,
  input logic       busWr,
  input logic [1:0] busAddr,
  input logic [7:0] busWdata,
  input logic [7:0] busRdata,
  input logic       chipResetOut,
  input logic       wdtLocalReset,
  input logic       wrapEvt,
  input logic       modeWd,
  input logic [7:0] countQ,
  input logic       flagQ,
  input logic       armQ,
  input logic       rstEnQ
);

  logic wdOvf, zeroWr, oneWr;
  assign wdOvf  = wrapEvt && modeWd;
  assign zeroWr = busSel && busWr && (busAddr == 2'd2) && !busWdata[7];
  assign oneWr  = busSel && busWr && (busAddr == 2'd2) && busWdata[7];

  a_r3_flag_source: assert property (@(posedge clk) disable iff (!rstPinN)
    $rose(flagQ) |-> $past(wdOvf));

  a_r3_interval_no_flag: assert property (@(posedge clk) disable iff (!rstPinN)
    (wrapEvt && !modeWd && !flagQ) |=> !flagQ);

  a_r4_one_write_keeps: assert property (@(posedge clk) disable iff (!rstPinN)
    (oneWr && !wdOvf) |=> (flagQ == $past(flagQ)));

  a_r5_clear_needs_arm: assert property (@(posedge clk) disable iff (!rstPinN)
    ($fell(flagQ) && $past(rstPinN)) |-> $past(armQ && zeroWr));

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rstPinN)
    wdOvf |=> flagQ);

  a_r7_local_after_ovf: assert property (@(posedge clk) disable iff (!rstPinN)
    wdOvf |=> (wdtLocalReset && countQ == 8'h00 && !modeWd));

  a_r7_local_source: assert property (@(posedge clk) disable iff (!rstPinN)
    (wdtLocalReset && $past(rstPinN)) |-> $past(wdOvf));

  a_r8_hold_zero: assert property (@(posedge clk) disable iff (!rstPinN)
    chipResetOut |-> (countQ == 8'h00));

  a_r9_chip_needs_enable: assert property (@(posedge clk) disable iff (!rstPinN)
    $rose(chipResetOut) |-> $past(wdOvf && rstEnQ));

  a_r10_reserved_ones: assert property (@(posedge clk) disable iff (!rstPinN)
    (busSel && !busWr && busAddr == 2'd2) |-> (busRdata[4:0] == 5'h1F));

endmodule

bind wdtResetCtl wdtResetCtlChecker u_chk (
  .clk           (clk),
  .rstPinN       (rstPinN),
  .busSel        (busSel),
  .busWr         (busWr),
  .busAddr       (busAddr),
  .busWdata      (busWdata),
  .busRdata      (busRdata),
  .chipResetOut  (chipResetOut),
  .wdtLocalReset (wdtLocalReset),
  .wrapEvt       (wrapEvt),
  .modeWd        (modeWd),
  .countQ        (countQ),
  .flagQ         (flagQ),
  .armQ          (armQ),
  .rstEnQ        (rstEnQ)
);

// File: tb/test_wdtResetCtl.sv
module test_wdtResetCtl;

  localparam int CLK_PERIOD = 10;
  localparam int PULSE_LEN  = 8;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstPinN = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0, tickEn = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       chipResetOut, wdtLocalReset;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [7:0] lastRd;

  // reference model state
  logic [7:0] mCnt;
  logic       mMode, mRun, mFlag, mArm, mEn, mType, mLocal;
  int         mPulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdtResetCtl #(.PULSE_LEN(PULSE_LEN)) i_wdtResetCtl (
    .clk(clk), .rstPinN(rstPinN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tickEn(tickEn), .chipResetOut(chipResetOut), .wdtLocalReset(wdtLocalReset)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0: return {mMode, mRun, 6'b0};
      2'd1: return mCnt;
      2'd2: return {mFlag, mEn, mType, 5'h1F};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rdTag(input logic [1:0] a);
    case (a)
      2'd0: return "R7 control read";
      2'd1: return "R2 counter read";
      2'd2: return "R3 status read";
      default: return "R12 unused read";
    endcase
  endfunction

  task automatic modelReset();
    mCnt = 8'h00; mMode = 0; mRun = 0; mFlag = 0; mArm = 0;
    mEn = 0; mType = 0; mLocal = 0; mPulse = 0;
  endtask

  // one bus cycle: drive after negedge, check read, advance model, check outputs
  task automatic cyc(input logic sel, input logic wr, input logic [1:0] addr,
                     input logic [7:0] data, input logic tick);
    logic hold, inc, cntWr, wrap, ovf, wr2, rd2, clr;
    logic [7:0] nCnt;
    logic nMode, nRun, nFlag, nArm, nEn, nType;
    int nPulse;
    busSel = sel; busWr = wr; busAddr = addr; busWdata = data; tickEn = tick;
    #1;
    lastRd = busRdata;
    if (sel && !wr && rstPinN) chk(rdTag(addr), busRdata, modelRead(addr));
    hold  = (mPulse != 0);
    inc   = mRun && tick && !hold;
    cntWr = sel && wr && addr == 2'd1 && !hold;
    wrap  = inc && !cntWr && mCnt == 8'hFF;
    ovf   = wrap && mMode;
    wr2   = sel && wr && addr == 2'd2;
    rd2   = sel && !wr && addr == 2'd2;
    clr   = wr2 && !data[7] && mArm;
    nCnt  = (hold || ovf) ? 8'h00 : cntWr ? data : inc ? mCnt + 8'h01 : mCnt;
    nMode = mMode; nRun = mRun;
    if (ovf) begin nMode = 0; nRun = 0; end
    else if (sel && wr && addr == 2'd0) begin nMode = data[7]; nRun = data[6]; end
    nFlag = ovf ? 1'b1 : clr ? 1'b0 : mFlag;
    nArm  = clr ? 1'b0 : (rd2 && mFlag) ? 1'b1 : mArm;
    nEn   = wr2 ? data[6] : mEn;
    nType = wr2 ? data[5] : mType;
    nPulse = (ovf && mEn) ? PULSE_LEN : (mPulse > 0 ? mPulse - 1 : 0);
    @(posedge clk);
    @(negedge clk);
    if (!rstPinN) modelReset();
    else begin
      mCnt = nCnt; mMode = nMode; mRun = nRun; mFlag = nFlag; mArm = nArm;
      mEn = nEn; mType = nType; mPulse = nPulse; mLocal = ovf;
    end
    chk("R8 chip reset output", chipResetOut, mPulse != 0);
    chk("R7 local reset output", wdtLocalReset, mLocal);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(1, 1, a, d, 0);
  endtask

  task automatic rdx(input logic [1:0] a, input logic [7:0] exp, input string req);
    cyc(1, 0, a, 8'h00, 0);
    chk(req, lastRd, exp);
  endtask

  task automatic idle(input logic tick);
    cyc(0, 0, 2'd0, 8'h00, tick);
  endtask

  task automatic pinReset();
    rstPinN = 0;
    idle(0);
    idle(0);
    chk("R1 chip reset low in pin reset", chipResetOut, 0);
    rstPinN = 1;
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
        finishRun();
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    modelReset();
    @(negedge clk);
    pinReset();
    // R1 reset values
    rdx(2, 8'h1F, "R1 status after pin");
    rdx(0, 8'h00, "R1 control after pin");
    rdx(1, 8'h00, "R1 counter after pin");
    // R10 reserved bits and reset type
    wr(2, 8'h00);
    rdx(2, 8'h1F, "R10 reserved read ones");
    wr(2, 8'h3F);
    rdx(2, 8'h3F, "R10 type bit stored");
    wr(2, 8'h00);
    // R12 unused address
    wr(3, 8'hFF);
    rdx(3, 8'h00, "R12 unused reads zero");
    rdx(0, 8'h00, "R12 write to unused no effect");
    // R3 interval wrap / R2 counting
    wr(0, 8'h40);
    wr(1, 8'hFF);
    idle(1);
    rdx(2, 8'h1F, "R3 interval wrap no flag");
    rdx(1, 8'h00, "R2 wrap to zero");
    idle(1); idle(0); idle(1);
    rdx(1, 8'h02, "R2 counts ticks only");
    // R7/R9 watchdog overflow with reset disabled
    wr(0, 8'hC0);
    wr(1, 8'hFE);
    idle(1);
    idle(1);
    chk("R7 local pulse", wdtLocalReset, 1);
    chk("R9 no chip reset", chipResetOut, 0);
    idle(0);
    chk("R7 local pulse one cycle", wdtLocalReset, 0);
    // R5 zero write without arm
    wr(2, 8'h00);
    rdx(2, 8'h9F, "R5 zero write unarmed keeps flag");
    wr(2, 8'h80);
    rdx(2, 8'h9F, "R4 write one no effect");
    wr(2, 8'h00);
    rdx(2, 8'h1F, "R5 armed zero write clears");
    rdx(0, 8'h00, "R7 control cleared");
    // R8/R11 chip reset pulse
    wr(2, 8'h40);
    wr(0, 8'hC0);
    wr(1, 8'hFF);
    idle(1);
    chk("R8 pulse start", chipResetOut, 1);
    for (int i = 0; i < PULSE_LEN - 1; i++) begin
      if (i == 2) wr(1, 8'h55);
      else if (i == 4) rdx(1, 8'h00, "R8 counter held");
      else idle(1);
      chk("R8 pulse held", chipResetOut, 1);
    end
    idle(0);
    chk("R8 pulse length", chipResetOut, 0);
    rdx(2, 8'hDF, "R11 flag survives chip reset");
    pinReset();
    rdx(2, 8'h1F, "R11 pin restores status");
    // R6 collision of overflow and armed clear
    wr(0, 8'hC0);
    wr(1, 8'hFF);
    idle(1);
    rdx(2, 8'h9F, "R3 flag set in watchdog mode");
    wr(0, 8'hC0);
    wr(1, 8'hFF);
    cyc(1, 1, 2'd2, 8'h00, 1);
    rdx(0, 8'h00, "R6 overflow occurred");
    wr(2, 8'h00);
    cyc(1, 0, 2'd2, 8'h00, 0);
    chk("R6 set wins and arm consumed", lastRd, 8'h9F);
    wr(2, 8'h00);
    rdx(2, 8'h1F, "R5 clear after fresh read");
    // R10 type bit has no effect on outputs
    wr(2, 8'h20);
    wr(0, 8'hC0);
    wr(1, 8'hFF);
    idle(1);
    chk("R10 type bit no chip reset", chipResetOut, 0);
    // random phase
    for (int n = 0; n < 6000; n++) begin
      logic [1:0] a;
      logic [7:0] d;
      logic s, w, t;
      if ($urandom_range(0, 799) == 0) begin
        pinReset();
      end
      s = ($urandom_range(0, 2) != 0);
      w = $urandom_range(0, 1);
      a = 2'($urandom_range(0, 3));
      d = 8'($urandom_range(0, 255));
      if (a == 2'd1 && $urandom_range(0, 1) == 1) d = 8'hFC | d[1:0];
      if (a == 2'd0 && $urandom_range(0, 3) != 0) d[6] = 1'b1;
      t = ($urandom_range(0, 9) < 7);
      cyc(s, w, a, d, t);
    end
    finishRun();
  end

endmodule